// File: doc/BRIEF.md
# Spare Row/Column Repair Allocator

This block performs built-in repair analysis for an embedded memory that carries one spare row and one spare column. While a self-test run is in progress, the test comparator reports each mismatch as a strobe with the failing row and failing column. The allocator decides, failure by failure, whether the two spares can cover every fault seen so far. It keeps the resulting repair addresses and enables, and raises a sticky flag when the faults go beyond what the spares can fix.

Allocation follows a must-repair rule. The first uncovered failure is held as pending and does not yet claim a spare. A later failure on the same row claims the spare row, and one on the same column claims the spare column. A failure on another row and another column makes the pending one take the spare row, or the spare column if the row is used. When the run ends, a pending failure takes whichever spare is still free, the row first.

The finished signature is captured in a repair-register chain and shifted out serially toward the fuse controller. The same repair registers drive a remap stage. That stage flags, in the same cycle, every access whose row or column must be steered onto a spare.

Top module: `spare_repair_alloc`

## Requirements
- R1: After reset both enables, both repair addresses, the unrepairable flag and the serial output are 0.
- R2: A failure that is not covered while no failure is pending becomes pending and sets neither enable. A failure with the same row and column as the pending one is ignored.
- R3: A failure that shares its row, but not its column, with the pending failure sets the row enable and the row repair address to that row on the next clock edge, and clears the pending failure. If the spare row is already in use, the unrepairable flag is set instead.
- R4: A failure that shares its column, but not its row, with the pending failure sets the column enable and the column repair address to that column on the next clock edge. If the spare column is already in use, the unrepairable flag is set instead.
- R5: A failure that shares neither address with the pending failure gives the pending failure the spare row, or the spare column if the row is used, and the new failure becomes pending. If no spare is left after that, the unrepairable flag is set and the new failure is dropped.
- R6: A failure whose row equals an enabled row repair address, or whose column equals an enabled column repair address, changes nothing.
- R7: The unrepairable flag is sticky: once set, it stays at 1 until a start pulse. An uncovered failure that arrives with no pending failure and no free spare also sets it.
- R8: An end-of-analysis pulse gives a pending failure the spare row if free, else the spare column, on the same edge. A failure strobe in a start or end cycle is ignored.
- R9: On the second clock edge after the end pulse, the chain loads {row enable, row address, column enable, column address}. The serial output then shows the chain MSB, so the row enable comes first. Each cycle with shift enable high moves the next bit out, and 0s follow the last bit.
- R10: The spare-row select is 1 exactly when the row enable is 1 and the access row equals the row repair address; the spare-column select works the same way with the column address. Both are combinational.
- R11: A start pulse clears both enables, both addresses, the pending failure and the unrepairable flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ana_start | input | 1 | Start of a new analysis run, clears all state |
| ana_done | input | 1 | End of analysis, resolves pending failure and triggers chain load |
| fail_valid | input | 1 | Failure report strobe from the comparator |
| fail_row | input | ROW_W | Failing row address |
| fail_col | input | COL_W | Failing column address |
| rep_row_en | output | 1 | Spare row in use |
| rep_row_addr | output | ROW_W | Row replaced by the spare row |
| rep_col_en | output | 1 | Spare column in use |
| rep_col_addr | output | COL_W | Column replaced by the spare column |
| unrepairable | output | 1 | Sticky flag: faults exceed the spares |
| chain_shift | input | 1 | Shift enable of the repair-register chain |
| chain_out | output | 1 | Serial output of the repair-register chain |
| acc_row | input | ROW_W | Access row address to be remapped |
| acc_col | input | COL_W | Access column address to be remapped |
| use_spare_row | output | 1 | Access must go to the spare row |
| use_spare_col | output | 1 | Access must go to the spare column |

## Verification
Every ordered pair of failure addresses on the 8x8 array is played as a run. One pair per run tells apart the four cases: identical, same row, same column and disjoint. The results are checked after each failure, after the end pulse and in the serial stream. Short directed runs cover the harder cases: failures on lines already spared, a third disjoint failure and a row conflict with the spare row in use. These runs check that the flag stays set and that a start pulse clears it. The remap stage is swept over all 64 access addresses with the spares enabled and with them disabled, to show that a match counts only while its enable is set.

// File: rtl/rra_pkg.sv
// Shared types of the spare repair allocator.
// Assumes: nothing beyond the standard language.
package rra_pkg;
    // Outcome of examining one failure report against the current state.
    typedef enum logic [2:0] {
        DEC_IGNORE,   // covered or duplicate: no change
        DEC_PEND,     // becomes the pending failure
        DEC_ROW,      // claims the spare row
        DEC_COL,      // claims the spare column
        DEC_SPLIT,    // pending takes a spare, new one becomes pending
        DEC_LAST,     // pending takes the last spare, new one is unrepairable
        DEC_FAIL      // no spare can cover it
    } rra_dec_e;
endpackage

// File: rtl/rra_analyzer.sv
// Repair analysis state machine for one spare row and one spare column.
// Holds at most one pending failure; allocates spares by the must-repair
// rule and keeps a sticky unrepairable flag.
// Assumes: start and done are single-cycle pulses; start wins over done,
// done wins over a failure strobe in the same cycle.
module rra_analyzer
    import rra_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic             fail_valid,
    input  logic [ROW_W-1:0] fail_row,
    input  logic [COL_W-1:0] fail_col,
    output logic             row_en,
    output logic [ROW_W-1:0] row_addr,
    output logic             col_en,
    output logic [COL_W-1:0] col_addr,
    output logic             unrep,
    output logic             sig_ready
);
    logic             pend_v;
    logic [ROW_W-1:0] pend_row;
    logic [COL_W-1:0] pend_col;
    logic             covered;
    logic             row_same;
    logic             col_same;
    logic             any_free;
    rra_dec_e         dec;

    // Classify the incoming failure against spares and the pending entry.
    always_comb begin
        covered  = (row_en && (fail_row == row_addr)) || (col_en && (fail_col == col_addr));
        row_same = pend_v && (fail_row == pend_row);
        col_same = pend_v && (fail_col == pend_col);
        any_free = !row_en || !col_en;
        dec      = DEC_IGNORE;
        if (covered || (row_same && col_same)) begin
            dec = DEC_IGNORE;
        end else if (row_same) begin
            dec = row_en ? DEC_FAIL : DEC_ROW;
        end else if (col_same) begin
            dec = col_en ? DEC_FAIL : DEC_COL;
        end else if (pend_v) begin
            dec = (!row_en && !col_en) ? DEC_SPLIT : DEC_LAST;
        end else begin
            dec = any_free ? DEC_PEND : DEC_FAIL;
        end
    end

    // Update spares, pending entry and flag on each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            row_en   <= 1'b0;
            row_addr <= '0;
            col_en   <= 1'b0;
            col_addr <= '0;
            pend_v   <= 1'b0;
            pend_row <= '0;
            pend_col <= '0;
            unrep    <= 1'b0;
        end else if (done) begin
            if (pend_v) begin
                if (!row_en) begin
                    row_en   <= 1'b1;
                    row_addr <= pend_row;
                end else if (!col_en) begin
                    col_en   <= 1'b1;
                    col_addr <= pend_col;
                end else begin
                    unrep    <= 1'b1;
                end
                pend_v <= 1'b0;
            end
        end else if (fail_valid) begin
            case (dec)
                DEC_PEND: begin
                    pend_v   <= 1'b1;
                    pend_row <= fail_row;
                    pend_col <= fail_col;
                end
                DEC_ROW: begin
                    row_en   <= 1'b1;
                    row_addr <= fail_row;
                    pend_v   <= 1'b0;
                end
                DEC_COL: begin
                    col_en   <= 1'b1;
                    col_addr <= fail_col;
                    pend_v   <= 1'b0;
                end
                DEC_SPLIT: begin
                    row_en   <= 1'b1;
                    row_addr <= pend_row;
                    pend_row <= fail_row;
                    pend_col <= fail_col;
                end
                DEC_LAST: begin
                    if (!row_en) begin
                        row_en   <= 1'b1;
                        row_addr <= pend_row;
                    end else begin
                        col_en   <= 1'b1;
                        col_addr <= pend_col;
                    end
                    pend_v <= 1'b0;
                    unrep  <= 1'b1;
                end
                DEC_FAIL: unrep <= 1'b1;
                default: ;
            endcase
        end
    end

    // Delay the end pulse by one cycle so the chain captures final values.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_ready <= 1'b0;
        else        sig_ready <= done && !start;
    end
endmodule

// File: rtl/rra_chain.sv
// Repair-register chain: parallel load of the signature, serial shift
// out MSB first with zero fill.
// Assumes: load has priority over shift.
module rra_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par_in,
    input  logic         shift,
    output logic         ser_out
);
    logic [W-1:0] sreg;

    // Capture or advance the chain contents.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= par_in;
        else if (shift) sreg <= {sreg[W-2:0], 1'b0};
    end

    assign ser_out = sreg[W-1];
endmodule

// File: rtl/rra_remap.sv
// Same-cycle remap decision: flags accesses that fall on a repaired row
// or column so the bypass multiplexers select the spare.
// Assumes: repair addresses are stable while accesses are made.
module rra_remap #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             row_en,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             col_en,
    input  logic [COL_W-1:0] col_addr,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    output logic             spare_row,
    output logic             spare_col
);
    // Compare the access address with each enabled repair address.
    always_comb begin
        spare_row = row_en && (acc_row == row_addr);
        spare_col = col_en && (acc_col == col_addr);
    end
endmodule

// File: rtl/spare_repair_alloc.sv
// Top of the spare row/column repair allocator: analysis, signature
// chain and access remap.
// Assumes: failure reports come from a comparator in the test clock domain.
module spare_repair_alloc #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ana_start,
    input  logic             ana_done,
    input  logic             fail_valid,
    input  logic [ROW_W-1:0] fail_row,
    input  logic [COL_W-1:0] fail_col,
    output logic             rep_row_en,
    output logic [ROW_W-1:0] rep_row_addr,
    output logic             rep_col_en,
    output logic [COL_W-1:0] rep_col_addr,
    output logic             unrepairable,
    input  logic             chain_shift,
    output logic             chain_out,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    output logic             use_spare_row,
    output logic             use_spare_col
);
    localparam int SIG_W = ROW_W + COL_W + 2;

    logic             sig_ready;
    logic [SIG_W-1:0] sig_vec;

    rra_analyzer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ana (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ana_start),
        .done       (ana_done),
        .fail_valid (fail_valid),
        .fail_row   (fail_row),
        .fail_col   (fail_col),
        .row_en     (rep_row_en),
        .row_addr   (rep_row_addr),
        .col_en     (rep_col_en),
        .col_addr   (rep_col_addr),
        .unrep      (unrepairable),
        .sig_ready  (sig_ready)
    );

    assign sig_vec = {rep_row_en, rep_row_addr, rep_col_en, rep_col_addr};

    rra_chain #(.W(SIG_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sig_ready),
        .par_in  (sig_vec),
        .shift   (chain_shift),
        .ser_out (chain_out)
    );

    rra_remap #(.ROW_W(ROW_W), .COL_W(COL_W)) u_remap (
        .row_en    (rep_row_en),
        .row_addr  (rep_row_addr),
        .col_en    (rep_col_en),
        .col_addr  (rep_col_addr),
        .acc_row   (acc_row),
        .acc_col   (acc_col),
        .spare_row (use_spare_row),
        .spare_col (use_spare_col)
    );
endmodule

// File: rtl/rra_chk.sv
// Checker for the spare repair allocator, bound to the top module.
// Assumes: synchronous active-low reset.
module rra_chk #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ana_start,
    input logic             rep_row_en,
    input logic [ROW_W-1:0] rep_row_addr,
    input logic             rep_col_en,
    input logic [COL_W-1:0] rep_col_addr,
    input logic             unrepairable,
    input logic [ROW_W-1:0] acc_row,
    input logic [COL_W-1:0] acc_col,
    input logic             use_spare_row,
    input logic             use_spare_col
);
    AST_UNREP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unrepairable && !ana_start |=> unrepairable); // R7
    AST_ROW_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rep_row_en && !ana_start |=> rep_row_en && $stable(rep_row_addr)); // R6
    AST_COL_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rep_col_en && !ana_start |=> rep_col_en && $stable(rep_col_addr)); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ana_start |=> !rep_row_en && !rep_col_en && !unrepairable); // R11
    AST_REMAP_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        use_spare_row |-> rep_row_en && (acc_row == rep_row_addr)); // R10
    AST_REMAP_COL: assert property (@(posedge clk) disable iff (!rst_n)
        use_spare_col |-> rep_col_en && (acc_col == rep_col_addr)); // R10
endmodule

bind spare_repair_alloc rra_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ana_start     (ana_start),
    .rep_row_en    (rep_row_en),
    .rep_row_addr  (rep_row_addr),
    .rep_col_en    (rep_col_en),
    .rep_col_addr  (rep_col_addr),
    .unrepairable  (unrepairable),
    .acc_row       (acc_row),
    .acc_col       (acc_col),
    .use_spare_row (use_spare_row),
    .use_spare_col (use_spare_col)
);

// File: tb/spare_repair_alloc_tb.sv
`timescale 1ns/1ps
module spare_repair_alloc_tb;
    localparam int RW = 3;
    localparam int CW = 3;
    localparam int SW = RW + CW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ana_start = 1'b0, ana_done = 1'b0, fail_valid = 1'b0, chain_shift = 1'b0;
    logic [RW-1:0] fail_row = '0, acc_row = '0, rep_row_addr;
    logic [CW-1:0] fail_col = '0, acc_col = '0, rep_col_addr;
    logic rep_row_en, rep_col_en, unrepairable, chain_out, use_spare_row, use_spare_col;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spare_repair_alloc #(.ROW_W(RW), .COL_W(CW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int state_word();
        return {unrepairable, rep_row_en, rep_row_addr, rep_col_en, rep_col_addr};
    endfunction

    task automatic chk_state(input string req, input bit u, input bit re, input int ra,
                             input bit ce, input int ca);
        int exp;
        exp = {u, re, re ? RW'(ra) : RW'(0), ce, ce ? CW'(ca) : CW'(0)};
        chk(state_word() == exp, req, state_word(), exp);
    endtask

    task automatic pulse_start();
        ana_start = 1'b1; @(negedge clk); ana_start = 1'b0;
    endtask
    task automatic pulse_done();
        ana_done = 1'b1; @(negedge clk); ana_done = 1'b0;
    endtask
    task automatic fail(input int r, input int c);
        fail_valid = 1'b1; fail_row = RW'(r); fail_col = CW'(c);
        @(negedge clk); fail_valid = 1'b0;
    endtask

    task automatic read_chain(output logic [SW-1:0] got);
        @(negedge clk);
        got[SW-1] = chain_out;
        chain_shift = 1'b1;
        for (int i = 1; i < SW; i++) begin
            @(negedge clk);
            got[SW-1-i] = chain_out;
        end
        @(negedge clk);
        chain_shift = 1'b0;
        chk(chain_out == 1'b0, "R9 zero fill", chain_out, 0);
    endtask

    task automatic sweep_remap(input string req, input bit re, input int ra, input bit ce, input int ca);
        for (int r = 0; r < (1 << RW); r++) begin
            for (int c = 0; c < (1 << CW); c++) begin
                acc_row = RW'(r); acc_col = CW'(c);
                #0.5;
                chk({use_spare_row, use_spare_col} == {re && r == ra, ce && c == ca},
                    req, {use_spare_row, use_spare_col}, {re && r == ra, ce && c == ca});
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [SW-1:0] got;
        logic [SW-1:0] exp_sig;
        bit er, ec;
        int ra, ca;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 reset", 0, 0, 0, 0, 0);
        chk(chain_out == 1'b0, "R1 chain reset", chain_out, 0);

        // Exhaustive two-failure runs.
        for (int r1 = 0; r1 < (1 << RW); r1++)
        for (int c1 = 0; c1 < (1 << CW); c1++)
        for (int r2 = 0; r2 < (1 << RW); r2++)
        for (int c2 = 0; c2 < (1 << CW); c2++) begin
            pulse_start();
            fail(r1, c1);
            chk_state("R2 first failure pending", 0, 0, 0, 0, 0);
            fail(r2, c2);
            if (r1 == r2 && c1 == c2) begin
                chk_state("R2 duplicate ignored", 0, 0, 0, 0, 0);
                er = 1; ra = r1; ec = 0; ca = 0;
            end else if (r1 == r2) begin
                chk_state("R3 shared row", 0, 1, r1, 0, 0);
                er = 1; ra = r1; ec = 0; ca = 0;
            end else if (c1 == c2) begin
                chk_state("R4 shared column", 0, 0, 0, 1, c1);
                er = 0; ra = 0; ec = 1; ca = c1;
            end else begin
                chk_state("R5 disjoint split", 0, 1, r1, 0, 0);
                er = 1; ra = r1; ec = 1; ca = c2;
            end
            pulse_done();
            chk_state("R8 end resolves pending", 0, er, ra, ec, ca);
            read_chain(got);
            exp_sig = {er, RW'(ra), ec, CW'(ca)};
            chk(got == exp_sig, "R9 serial signature", got, exp_sig);
        end

        // R10: remap sweep with both spares, then with none.
        pulse_start();
        fail(3, 5); fail(6, 2); pulse_done();
        sweep_remap("R10 remap enabled", 1, 3, 1, 2);
        pulse_start();
        sweep_remap("R10 remap disabled", 0, 0, 0, 0);

        // R6: failures on a spared row or column are ignored.
        fail(2, 5); fail(2, 6);
        chk_state("R3 row claimed", 0, 1, 2, 0, 0);
        fail(2, 1);
        chk_state("R6 covered row ignored", 0, 1, 2, 0, 0);
        fail(4, 4); pulse_done();
        chk_state("R6 covered not pending", 0, 1, 2, 1, 4);
        fail(7, 4); fail(2, 0);
        chk_state("R6 covered by both", 0, 1, 2, 1, 4);
        fail(5, 5);
        chk_state("R7 no spare left", 1, 1, 2, 1, 4);

        // R5/R7: third disjoint failure uses the last spare and overflows.
        pulse_start();
        chk_state("R11 start clears", 0, 0, 0, 0, 0);
        fail(0, 0); fail(1, 1);
        chk_state("R5 pending gets row", 0, 1, 0, 0, 0);
        fail(2, 2);
        chk_state("R5 last spare overflow", 1, 1, 0, 1, 1);
        repeat (4) @(negedge clk);
        fail(1, 1);
        chk_state("R7 sticky", 1, 1, 0, 1, 1);
        pulse_done();
        read_chain(got);
        exp_sig = {1'b1, RW'(0), 1'b1, CW'(1)};
        chk(got == exp_sig, "R9 chain after overflow", got, exp_sig);

        // R3: row conflict with the spare row already used.
        pulse_start();
        fail(0, 0); fail(1, 1); fail(1, 2);
        chk_state("R3 row used conflict", 1, 1, 0, 0, 0);

        // R8: failure strobe together with end pulse is ignored.
        pulse_start();
        ana_done = 1'b1; fail(6, 6); ana_done = 1'b0;
        chk_state("R8 strobe at end ignored", 0, 0, 0, 0, 0);
        pulse_done();
        chk_state("R8 nothing pending", 0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule